// File: doc/BRIEF.md
# Complementary PWM Channel Generator

This block produces one pulse-width-modulated waveform on a primary output together with a complementary output. A frame has two phases. The active phase lasts while the frame position is below a compare length. The idle phase lasts from there to the end of the frame, which is set by a max length. A polarity control swaps the levels of the two phases. Each output then passes through its own inversion control. Both lengths arrive packed in one 32-bit configuration word.

The frame position advances only on cycles where an external clock-divider tick enable is high. A new configuration is taken up at frame boundaries and while the channel is disabled. The block counts completed frames in a readable 16-bit counter. It raises a frame-done status flag, which software clears by writing one. The interrupt output is the status flag gated by a mask.

Top module: `pwm_comp_channel`

## Requirements
- R1: `periodCfg[15:0]` is the compare length C and `periodCfg[31:16]` is the max length M. A frame lasts M ticks, and M = 0 behaves as a frame of 1 tick.
- R2: While enabled, the frame position p runs from 0 to max(M,1)-1. With `polarity`=0 the primary waveform is high when p < C and low otherwise. With `polarity`=1 the waveform is the logical inverse of that.
- R3: `invPrimary`=1 inverts `pwmOut` and does not affect `pwmOutN`.
- R4: `pwmOutN` is the inverse of the primary waveform before inversion, then XORed with `invComp`. `invComp` does not affect `pwmOut`.
- R5: A change of `periodCfg` during an enabled frame takes effect only at the start of the next frame.
- R6: `frameDone` becomes 1 in the cycle after the tick that completes a frame.
- R7: A cycle with `clearStatus`=1 clears `frameDone`, unless a frame completes in the same cycle, in which case the flag stays set.
- R8: `irq` equals `frameDone` AND `irqMask`.
- R9: `pulseCount` increments by one for each completed frame and wraps from 65535 to 0.
- R10: When `enable`=0, both raw waveforms are low, so `pwmOut`=`invPrimary` and `pwmOutN`=`invComp`. The frame position and `pulseCount` become 0, and `frameDone` keeps its value.
- R11: The frame position and `pulseCount` change only on enabled cycles with `tickEn`=1.
- R12: After reset, `frameDone`=0 and `pulseCount`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Count enable from the external divider |
| enable | input | 1 | Channel run control |
| polarity | input | 1 | Swaps the phase levels |
| invPrimary | input | 1 | Inverts the primary output |
| invComp | input | 1 | Inverts the complementary output |
| periodCfg | input | 32 | Max length in [31:16], compare length in [15:0] |
| irqMask | input | 1 | Interrupt mask for frame-done |
| clearStatus | input | 1 | Write-one-to-clear strobe for frame-done |
| pwmOut | output | 1 | Primary output |
| pwmOutN | output | 1 | Complementary output |
| frameDone | output | 1 | Frame-done status flag |
| irq | output | 1 | Masked interrupt |
| pulseCount | output | 16 | Completed frame count |

## Verification
A corrupted frame position or a stale compare or max register shows up as a wrong duty or period on both outputs. The error becomes visible within one frame, at the first active-to-idle edge or the first frame completion. A wrong status or frame counter shows up one cycle after the completing tick, as a missing or extra `frameDone`, a wrong `irq`, or a `pulseCount` off by one. Each output is compared against an independent model every cycle, so any divergence is reported on the cycle it appears.

// File: rtl/pwm_comp_pkg.sv
package pwm_comp_pkg;
  // Strobes issued by the control module to the datapath each cycle.
  typedef struct packed {
    logic clear;    // channel disabled: zero counters
    logic wrap;     // last tick of a frame
    logic advance;  // ordinary tick inside a frame
    logic reload;   // take up a new configuration
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_comp_ctrl.sv
module pwm_comp_ctrl
  import pwm_comp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tickEn,
  input  logic       atLast,
  input  logic       clearStatus,
  output pwmStrobe_t strobes,
  output logic       frameDone
);

  always_comb begin
    strobes.clear   = !enable;
    strobes.wrap    = enable && tickEn && atLast;
    strobes.advance = enable && tickEn && !atLast;
    strobes.reload  = strobes.clear || strobes.wrap;
  end

  // Completion has priority over a software clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             frameDone <= 1'b0;
    else if (strobes.wrap) frameDone <= 1'b1;
    else if (clearStatus)  frameDone <= 1'b0;
  end

  a_r6_set_on_frame: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tickEn && atLast) |=> frameDone);

  a_r7_clear_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (clearStatus && !(enable && tickEn && atLast)) |=> !frameDone);

  a_r10_status_held: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !clearStatus) |=> $stable(frameDone));

endmodule

// File: rtl/pwm_comp_datapath.sv
module pwm_comp_datapath
  import pwm_comp_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  pwmStrobe_t         strobes,
  input  logic [2*SEG_W-1:0] periodCfg,
  input  logic               enable,
  input  logic               polarity,
  input  logic               invPrimary,
  input  logic               invComp,
  output logic               atLast,
  output logic               pwmOut,
  output logic               pwmOutN,
  output logic [CNT_W-1:0]   pulseCount
);

  localparam logic [SEG_W-1:0] SEG_ONE = SEG_W'(1);

  logic [SEG_W-1:0] framePos;
  logic [SEG_W-1:0] activeCmp;
  logic [SEG_W-1:0] activeMax;
  logic [SEG_W-1:0] lastPos;
  logic             inCompare;
  logic             rawWave;

  assign lastPos = (activeMax == '0) ? '0 : activeMax - SEG_ONE;
  assign atLast  = (framePos >= lastPos);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      framePos   <= '0;
      pulseCount <= '0;
    end else if (strobes.clear) begin
      framePos   <= '0;
      pulseCount <= '0;
    end else if (strobes.wrap) begin
      framePos   <= '0;
      pulseCount <= pulseCount + CNT_W'(1);
    end else if (strobes.advance) begin
      framePos   <= framePos + SEG_ONE;
    end
  end

  // Shadow copies of the segment lengths, refreshed only at boundaries.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCmp <= '0;
      activeMax <= '0;
    end else if (strobes.reload) begin
      activeCmp <= periodCfg[SEG_W-1:0];
      activeMax <= periodCfg[2*SEG_W-1:SEG_W];
    end
  end

  assign inCompare = (framePos < activeCmp);
  assign rawWave   = inCompare ^ polarity;
  assign pwmOut    = (enable &  rawWave) ^ invPrimary;
  assign pwmOutN   = (enable & ~rawWave) ^ invComp;

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !strobes.advance && !strobes.wrap) |=> ($stable(framePos) && $stable(pulseCount)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (framePos == '0 && pulseCount == '0));

  a_r9_pulse_step: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrap |=> (pulseCount == $past(pulseCount) + CNT_W'(1)));

  a_r5_shadow_stable: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.reload |=> ($stable(activeCmp) && $stable(activeMax)));

  a_r2_pos_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    strobes.advance |=> (framePos != '0));

endmodule

// File: rtl/pwm_comp_channel.sv
module pwm_comp_channel
  import pwm_comp_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  logic               enable,
  input  logic               polarity,
  input  logic               invPrimary,
  input  logic               invComp,
  input  logic [2*SEG_W-1:0] periodCfg,
  input  logic               irqMask,
  input  logic               clearStatus,
  output logic               pwmOut,
  output logic               pwmOutN,
  output logic               frameDone,
  output logic               irq,
  output logic [CNT_W-1:0]   pulseCount
);

  pwmStrobe_t strobes;
  logic       atLast;

  pwm_comp_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .tickEn      (tickEn),
    .atLast      (atLast),
    .clearStatus (clearStatus),
    .strobes     (strobes),
    .frameDone   (frameDone)
  );

  pwm_comp_datapath #(.SEG_W(SEG_W), .CNT_W(CNT_W)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .periodCfg  (periodCfg),
    .enable     (enable),
    .polarity   (polarity),
    .invPrimary (invPrimary),
    .invComp    (invComp),
    .atLast     (atLast),
    .pwmOut     (pwmOut),
    .pwmOutN    (pwmOutN),
    .pulseCount (pulseCount)
  );

  assign irq = frameDone & irqMask;

  a_r8_masked_irq: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (frameDone && irqMask));

endmodule

// File: tb/test_pwm_comp_channel.sv
module test_pwm_comp_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, enable = 1'b0, polarity = 1'b0;
  logic        invPrimary = 1'b0, invComp = 1'b0, irqMask = 1'b0, clearStatus = 1'b0;
  logic [31:0] periodCfg = '0;
  logic        pwmOut, pwmOutN, frameDone, irq;
  logic [15:0] pulseCount;

  always #4 clk = ~clk;  // 125 MHz

  pwm_comp_channel i_pwm_comp_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .enable(enable), .polarity(polarity),
    .invPrimary(invPrimary), .invComp(invComp), .periodCfg(periodCfg),
    .irqMask(irqMask), .clearStatus(clearStatus), .pwmOut(pwmOut), .pwmOutN(pwmOutN),
    .frameDone(frameDone), .irq(irq), .pulseCount(pulseCount)
  );

  typedef struct packed {
    logic        out;
    logic        outN;
    logic        stat;
    logic        irq;
    logic [15:0] pulse;
  } expect_t;

  expect_t     sbQueue[$];
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  // reference model state
  logic [15:0] mPos = '0, mCmp = '0, mMax = '0, mPulse = '0;
  logic        mStat = 1'b0;

  task automatic checkEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: applies one cycle of inputs and pushes the expected outputs.
  task automatic step(input bit en, input bit tk, input bit pol, input bit ip, input bit ic,
                      input logic [31:0] cfg, input bit msk, input bit clr);
    logic [15:0] last;
    logic        act, raw;
    expect_t     e;
    @(negedge clk);
    enable = en; tickEn = tk; polarity = pol; invPrimary = ip; invComp = ic;
    periodCfg = cfg; irqMask = msk; clearStatus = clr;
    if (!en) begin
      mPos = '0; mPulse = '0; mCmp = cfg[15:0]; mMax = cfg[31:16];
      if (clr) mStat = 1'b0;
    end else if (tk) begin
      last = (mMax == 0) ? 16'd0 : mMax - 16'd1;
      if (mPos >= last) begin
        mPos = '0; mPulse = mPulse + 16'd1; mStat = 1'b1;
        mCmp = cfg[15:0]; mMax = cfg[31:16];
      end else begin
        mPos = mPos + 16'd1;
        if (clr) mStat = 1'b0;
      end
    end else if (clr) begin
      mStat = 1'b0;
    end
    act    = (mPos < mCmp);
    raw    = act ^ pol;
    e.out  = (en & raw) ^ ip;
    e.outN = (en & ~raw) ^ ic;
    e.stat = mStat;
    e.irq  = mStat & msk;
    e.pulse = mPulse;
    sbQueue.push_back(e);
  endtask

  // Monitor: compares the design against the queued expectations.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sbQueue.size() > 0) begin
        expect_t e;
        e = sbQueue.pop_front();
        checkEq("R2/R3", "pwmOut", int'(pwmOut), int'(e.out));
        checkEq("R4", "pwmOutN", int'(pwmOutN), int'(e.outN));
        checkEq("R6/R7", "frameDone", int'(frameDone), int'(e.stat));
        checkEq("R8", "irq", int'(irq), int'(e.irq));
        checkEq("R9", "pulseCount", int'(pulseCount), int'(e.pulse));
      end
    end
  end

  task automatic runFor(input int n, input bit pol, input bit ip, input bit ic,
                        input logic [31:0] cfg, input int tickEvery, input bit msk);
    for (int i = 0; i < n; i++)
      step(1'b1, (i % tickEvery) == 0, pol, ip, ic, cfg, msk, 1'b0);
  endtask

  initial begin
    #20;
    @(negedge clk);
    // R12: reset state while still in reset
    checkEq("R12", "frameDone in reset", int'(frameDone), 0);
    checkEq("R12", "pulseCount in reset", int'(pulseCount), 0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1'b0, 1'b0);
    // R1 R2: compare 3, max 8, tick every cycle, polarity 0
    runFor(20, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1, 1'b1);
    // R7: clear status, R8 mask off
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1'b0, 1'b1);
    // R11: tick every third cycle
    runFor(40, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 3, 1'b0);
    // R2 polarity 1, R3 R4 inversion combinations
    runFor(16, 1'b1, 1'b0, 1'b0, 32'h0005_0002, 1, 1'b1);
    runFor(16, 1'b0, 1'b1, 1'b0, 32'h0005_0002, 1, 1'b1);
    runFor(16, 1'b0, 1'b0, 1'b1, 32'h0005_0002, 1, 1'b1);
    runFor(16, 1'b1, 1'b1, 1'b1, 32'h0005_0002, 1, 1'b1);
    // R5: change config mid-frame
    runFor(3, 1'b0, 1'b0, 1'b0, 32'h0006_0004, 1, 1'b1);
    runFor(20, 1'b0, 1'b0, 1'b0, 32'h0004_0001, 1, 1'b1);
    // R7: clear held while frames complete (set wins)
    for (int i = 0; i < 12; i++)
      step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0004_0001, 1'b1, 1'b1);
    // R1 edge cases: compare >= max, max = 0
    runFor(12, 1'b0, 1'b0, 1'b0, 32'h0003_0009, 1, 1'b1);
    runFor(6, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1, 1'b1);
    // R10: disable mid-frame with inversions set, status kept
    runFor(3, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1, 1'b1);
    for (int i = 0; i < 5; i++)
      step(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0008_0003, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1'b1, 1'b1);
    runFor(10, 1'b0, 1'b0, 1'b0, 32'h0008_0003, 1, 1'b1);
    // R9: wrap of pulse counter with one-tick frames
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0001_0001, 1'b0, 1'b0);
    runFor(65540, 1'b0, 1'b0, 1'b0, 32'h0001_0001, 1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule